// File: doc/BRIEF.md
# Automatic RTS/CTS Handshake Controller

This block runs the hardware handshake of one serial channel without any help from software. On the receive side it watches how full the receive FIFO is and drives the ready-to-send output. It lowers that output when the FIFO reaches a programmable halt level. It raises it again only after the FIFO has drained to a lower resume level. Both levels sit in one 8-bit threshold word, as two 4-bit fields, and each field is scaled so that it covers the whole FIFO.

On the transmit side the block synchronizes the clear-to-send input and produces a permit flag for the transmitter. The transmitter looks at this flag before it starts each new character. While the line is idle the flag follows CTS. While a character is being sent, CTS is captured only once, at the middle of that character's last stop bit. A CTS drop earlier in the character therefore never cuts it short, and a drop before that midpoint blocks the next character. Every change of the synchronized CTS also produces a single-cycle event for the interrupt logic.

Top module: `hw_handshake_ctrl`

## Requirements
- R1: With auto-RTS on, `rts_o` (1 = ready to receive) is 0 from the clock edge after `rx_level` is at or above the halt level. The halt level is `flow_thr[3:0]` times FIFO_DEPTH/16, which is 4 for a 64-entry FIFO.
- R2: Once halted, `rts_o` returns to 1 only from the edge after `rx_level` is at or below the resume level, `flow_thr[7:4]` times the same scale. At levels between the resume and halt levels, `rts_o` keeps its previous value.
- R3: The halt comparison takes priority over the resume comparison. If the fields overlap, the halt test wins, and a halt field of 0 keeps `rts_o` at 0 at every level.
- R4: With auto-RTS off, `rts_o` takes the value of `sw_rts` one cycle later, and the halted state is cleared.
- R5: `cts_i` (1 = peer ready) passes through SYNC_STAGES flip-flops before any use.
- R6: While `tx_busy` is 0, the internal permit captures the synchronized CTS on every edge.
- R7: While `tx_busy` is 1, the permit is captured only on an edge where `tx_stop_mid` is 1, and it holds at every other edge. A CTS change in the middle of a character therefore does not affect that character.
- R8: With auto-CTS off, `tx_permit` is 1. With auto-CTS on, `tx_permit` equals the internal permit.
- R9: `cts_event` is 1 for exactly one cycle after each change of the synchronized CTS.
- R10: While `rst_n` is 0, `rts_o`, `cts_event` and the internal permit are 0, and the synchronizer and the halted state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W (7) | Current receive FIFO fill count, 0..FIFO_DEPTH |
| flow_thr | input | 8 | [3:0] halt field, [7:4] resume field |
| auto_rts_en | input | 1 | Enables automatic RTS |
| auto_cts_en | input | 1 | Enables automatic CTS gating |
| sw_rts | input | 1 | Software RTS value, used when auto-RTS is off |
| cts_i | input | 1 | Asynchronous clear-to-send from the peer, 1 = ready |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_stop_mid | input | 1 | One-cycle pulse at the middle of the last stop bit |
| rts_o | output | 1 | Ready-to-send toward the peer, 1 = ready |
| tx_permit | output | 1 | Transmitter may start its next character |
| cts_event | output | 1 | One-cycle pulse on each synchronized CTS change |

## Verification
The bench builds the block with FIFO_DEPTH = 64 and SYNC_STAGES = 3. At these values every scaled threshold from 0 to 60 and the full count of 64 can be reached. The three-stage chain makes the CTS latency long enough that a synchronizer stage added or dropped shifts both the event and the permit by a visible cycle. The threshold sweeps include overlapping fields and a zero halt field, so the halt-over-resume priority is exercised as well as the normal hysteresis band.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] resume;
    logic [FIELD_W-1:0] halt;
  } thr_fields_t;
endpackage

// File: rtl/hs_rts_hyst.sv
module hs_rts_hyst
  import hs_pkg::*;
#(
  parameter int LVL_W = 7,
  parameter int SH    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             sw_rts,
  input  logic [LVL_W-1:0] level,
  input  thr_fields_t      thr,
  output logic             rts_o
);
  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;
  logic             halted_q, halted_d;
  logic             rts_q, rts_d;

  assign halt_lvl   = LVL_W'(thr.halt) << SH;
  assign resume_lvl = LVL_W'(thr.resume) << SH;

  always_comb begin
    halted_d = halted_q;
    if (!auto_en)
      halted_d = 1'b0;
    else if (level >= halt_lvl)
      halted_d = 1'b1;
    else if (level <= resume_lvl)
      halted_d = 1'b0;
    rts_d = auto_en ? ~halted_d : sw_rts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      rts_q    <= 1'b0;
    end else begin
      halted_q <= halted_d;
      rts_q    <= rts_d;
    end
  end

  assign rts_o = rts_q;

  AST_HALT_DROPS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && level >= halt_lvl) |=> !rts_o); // R1
  AST_RESUME_RAISES_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && level < halt_lvl && level <= resume_lvl) |=> rts_o); // R2
  AST_SW_RTS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_o == $past(sw_rts))); // R4
endmodule

// File: rtl/hs_cts_sync.sv
module hs_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_i,
  output logic cts_s,
  output logic cts_event
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = cts_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], cts_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign cts_s     = chain_q[STAGES-1];
  assign cts_event = cts_s ^ prev_q;
endmodule

// File: rtl/hs_cts_gate.sv
module hs_cts_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_s,
  input  logic tx_busy,
  input  logic tx_stop_mid,
  output logic permit_q
);
  logic cap_en;
  logic permit_d;

  assign cap_en   = ~tx_busy | tx_stop_mid;
  assign permit_d = cap_en ? cts_s : permit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      permit_q <= 1'b0;
    else
      permit_q <= permit_d;
  end

  AST_PERMIT_HELD_MIDCHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_stop_mid) |=> $stable(permit_q)); // R7
  AST_PERMIT_TRACKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |=> (permit_q == $past(cts_s))); // R6
endmodule

// File: rtl/hw_handshake_ctrl.sv
module hw_handshake_ctrl
  import hs_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [7:0]       flow_thr,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             sw_rts,
  input  logic             cts_i,
  input  logic             tx_busy,
  input  logic             tx_stop_mid,
  output logic             rts_o,
  output logic             tx_permit,
  output logic             cts_event
);
  localparam int SH = $clog2(FIFO_DEPTH) - FIELD_W;

  thr_fields_t thr;
  logic        cts_s;
  logic        permit_q;

  assign thr = flow_thr;

  hs_rts_hyst #(.LVL_W(LVL_W), .SH(SH)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .sw_rts(sw_rts),
    .level(rx_level), .thr(thr), .rts_o(rts_o)
  );

  hs_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .cts_s(cts_s), .cts_event(cts_event)
  );

  hs_cts_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cts_s(cts_s), .tx_busy(tx_busy),
    .tx_stop_mid(tx_stop_mid), .permit_q(permit_q)
  );

  assign tx_permit = ~auto_cts_en | permit_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!rts_o && !cts_event)); // R10
endmodule

// File: tb/hw_handshake_ctrl_tb_top.sv
`timescale 1ns/1ps
module hw_handshake_ctrl_tb_top;
  localparam int DEPTH = 64;
  localparam int NS    = 3;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic [LW-1:0] rx_level = '0;
  logic [7:0] flow_thr = 8'h00;
  logic auto_rts_en = 0, auto_cts_en = 0, sw_rts = 0, cts_i = 0;
  logic tx_busy = 0, tx_stop_mid = 0;
  logic rts_o, tx_permit, cts_event;

  int n_cmp = 0, n_bad = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  hw_handshake_ctrl #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .flow_thr(flow_thr),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .sw_rts(sw_rts),
    .cts_i(cts_i), .tx_busy(tx_busy), .tx_stop_mid(tx_stop_mid),
    .rts_o(rts_o), .tx_permit(tx_permit), .cts_event(cts_event)
  );

  // behavioural reference
  bit m_sync[$];
  bit m_prev, m_halted, m_rts, m_permit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = {};
      for (int i = 0; i < NS; i++) m_sync.push_back(1'b0);
      m_prev = 0; m_halted = 0; m_rts = 0; m_permit = 0;
    end else begin
      int hl, rl;
      bit hn, old_s;
      old_s = m_sync[NS-1];
      hl = int'(flow_thr[3:0]) * (DEPTH / 16);
      rl = int'(flow_thr[7:4]) * (DEPTH / 16);
      if (!auto_rts_en) hn = 0;
      else if (int'(rx_level) >= hl) hn = 1;
      else if (int'(rx_level) <= rl) hn = 0;
      else hn = m_halted;
      m_halted = hn;
      m_rts = auto_rts_en ? !hn : sw_rts;
      if (!tx_busy || tx_stop_mid) m_permit = old_s;
      m_prev = old_s;
      void'(m_sync.pop_back());
      m_sync.push_front(cts_i);
    end
  end

  task automatic chk(input string t, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk(tag, rts_o, m_rts, "rts_o");
      chk(tag, tx_permit, !auto_cts_en | m_permit, "tx_permit");
      chk(tag, cts_event, m_sync[NS-1] ^ m_prev, "cts_event");
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    cts_i = 1;
    #12;
    chk("R10", rts_o, 1'b0, "rts_o in reset");
    chk("R10", cts_event, 1'b0, "cts_event in reset");
    chk("R10", tx_permit, 1'b1, "tx_permit auto-cts off");
    @(negedge clk); rst_n = 1;
    tag = "R5"; step(6);

    // R1 rising sweep, halt 48 resume 32
    tag = "R1"; auto_rts_en = 1; flow_thr = 8'h8C;
    for (int v = 0; v <= DEPTH; v++) begin rx_level = LW'(v); step(1); end
    chk("R1", rts_o, 1'b0, "halted at full");
    // R2 falling sweep through the band
    tag = "R2";
    for (int v = DEPTH; v >= 0; v--) begin
      rx_level = LW'(v); step(1);
      if (v == 40) chk("R2", rts_o, 1'b0, "band keeps halt");
    end
    chk("R2", rts_o, 1'b1, "resumed at empty");
    rx_level = 7'd40; step(2);
    chk("R2", rts_o, 1'b1, "band keeps ready");

    // R3 overlapping fields and zero halt
    tag = "R3"; flow_thr = 8'hF4; rx_level = 7'd20; step(2);
    chk("R3", rts_o, 1'b0, "halt wins overlap");
    rx_level = 7'd10; step(2);
    chk("R3", rts_o, 1'b1, "release below halt");
    flow_thr = 8'h50; rx_level = 7'd0; step(3);
    chk("R3", rts_o, 1'b0, "zero halt field");

    // R4 software RTS
    tag = "R4"; auto_rts_en = 0;
    for (int k = 0; k < 8; k++) begin sw_rts = k[0]; step(1); end
    sw_rts = 1; step(1); chk("R4", rts_o, 1'b1, "sw_rts high");

    // R9/R6 idle CTS tracking with auto-CTS on
    tag = "R9"; auto_cts_en = 1;
    cts_i = 0; step(6); cts_i = 1; step(6); cts_i = 0; step(1); cts_i = 1; step(6);
    tag = "R6"; cts_i = 0; step(6);
    chk("R6", tx_permit, 1'b0, "idle permit follows cts low");

    // R7 busy character: change mid-char, capture at stop midpoint
    tag = "R7"; cts_i = 1; step(6); tx_busy = 1; cts_i = 0; step(8);
    chk("R7", tx_permit, 1'b1, "held during char");
    tx_stop_mid = 1; step(1); tx_stop_mid = 0; step(2);
    chk("R7", tx_permit, 1'b0, "captured at stop mid");
    cts_i = 1; step(8);
    chk("R7", tx_permit, 1'b0, "held again");
    tx_busy = 0; step(2);

    // R8 auto-CTS off
    tag = "R8"; auto_cts_en = 0; cts_i = 0; step(6);
    chk("R8", tx_permit, 1'b1, "auto-cts off");

    // mixed random traffic
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      rx_level    = LW'($urandom_range(0, DEPTH));
      cts_i       = $urandom_range(0, 3) == 0 ? ~cts_i : cts_i;
      tx_busy     = $urandom_range(0, 3) != 0;
      tx_stop_mid = $urandom_range(0, 7) == 0;
      auto_rts_en = $urandom_range(0, 9) != 0;
      auto_cts_en = $urandom_range(0, 9) != 0;
      sw_rts      = $urandom_range(0, 1) == 1;
      if (k % 200 == 0) flow_thr = 8'($urandom);
      step(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule